// File: doc/BRIEF.md
# Key-Committed Memory Map Controller

This block sits on a byte-wide register bus and decides, for every code-space and data-space address the processor issues, whether that address belongs to the flash array or to the boot ROM, and at what local offset. Software never changes the mapping in a single write. It first loads a value into a staging control register. It then writes a fixed unlock byte to a separate key address. Only the unlock byte moves the staged value into the active control register that drives the decoders.

The active value is read on a dedicated monitor output, apart from the bus readback of the staged value. One bit of the active value turns on a 2 KB window at the bottom of the mapped region. In that window the boot ROM is laid over the flash in both spaces. Outside the window, and always when the bit is clear, flash answers the whole upper region.

Top module: `memmap_keyed_ctrl`

## Requirements
- R1: After reset, the staged and active control values are both 0x00, so the overlay is off and `mon_active` reads 0x00.
- R2: A bus write to address 0x0FD0 loads the staging register. From the next cycle `reg_rdata` shows that value at 0x0FD0. `mon_active` and the decoded mapping stay unchanged.
- R3: A bus write of 0xD5 to address 0x0FD1 copies the staging value into the active register on that clock edge. The copied value appears on `mon_active` in the next cycle.
- R4: A write of any byte other than 0xD5 to 0x0FD1 leaves the active register unchanged. A read of 0x0FD1, or of any other address except 0x0FD0, returns 0x00.
- R5: `mon_active` always presents the full active control byte.
- R6: With the overlay off, every address from 0x1000 to 0xFFFF asserts the flash select, in both spaces, and never the ROM select.
- R7: With active bit 5 set, addresses 0x1000 to 0x17FF assert the ROM select and not the flash select, in both spaces. Addresses 0x1800 to 0xFFFF still select flash.
- R8: Addresses below 0x1000 assert neither select. For a selected address the offset output equals the address minus 0x1000, and it is zero below 0x1000.
- R9: Active bits other than bit 5 are stored and shown on `mon_active`, but they do not change decoding.
- R10: A decode in the same cycle as the committing key write still uses the old mapping. A decode in the following cycle uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 16 | Register bus byte address |
| reg_wr | input | 1 | Register bus write strobe |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data for `reg_addr` |
| mon_active | output | 8 | Active control byte (monitor) |
| code_addr | input | 16 | Code-space address to decode |
| code_flash_sel | output | 1 | Code-space access goes to flash |
| code_rom_sel | output | 1 | Code-space access goes to boot ROM |
| code_offset | output | 16 | Code-space offset into the selected target |
| data_addr | input | 16 | Data-space address to decode |
| data_flash_sel | output | 1 | Data-space access goes to flash |
| data_rom_sel | output | 1 | Data-space access goes to boot ROM |
| data_offset | output | 16 | Data-space offset into the selected target |

## Verification
A key commit and an address decode can happen in the same cycle. The decode inputs are not held off while a register write is in progress. The bench provokes this by driving the 0xD5 key write together with window addresses in both spaces. It judges the decode result twice: inside the write cycle, where the old mapping must still hold, and one cycle later, where the new mapping must hold. The random phase mixes staging writes, wrong and right keys and address probes. This lets commits land next to decodes at unplanned points, and a bench model of staged and active values predicts every result.

// File: rtl/mmk_pkg.sv
package mmk_pkg;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_ROM   = 2'd2
  } tgt_e;

  // Target chosen for one address given region base, overlay window size and overlay state
  function automatic tgt_e pick_target(input logic [31:0] addr,
                                       input logic [31:0] base,
                                       input logic [31:0] win,
                                       input logic        overlay);
    if (addr < base)                         return TGT_NONE;
    else if (overlay && (addr < base + win)) return TGT_ROM;
    else                                     return TGT_FLASH;
  endfunction

  // Offset within the mapped region, zero below it
  function automatic logic [31:0] local_off(input logic [31:0] addr,
                                            input logic [31:0] base);
    return (addr >= base) ? (addr - base) : 32'd0;
  endfunction

endpackage

// File: rtl/mmk_ctrl_regs.sv
module mmk_ctrl_regs #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 32'h0FD0,
  parameter int unsigned KEY_ADDR  = 32'h0FD1,
  parameter int unsigned KEY_VAL   = 32'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] staging,
  output logic [DATA_W-1:0] active,
  output logic              commit_evt
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] KEY_A  = ADDR_W'(KEY_ADDR);
  localparam logic [DATA_W-1:0] KEY_B  = DATA_W'(KEY_VAL);

  logic stage_wr_evt;
  logic key_wr_evt;

  assign stage_wr_evt = bus_wr && (bus_addr == CTRL_A);
  assign key_wr_evt   = bus_wr && (bus_addr == KEY_A);
  assign commit_evt   = key_wr_evt && (bus_wdata == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staging <= '0;
    end else if (stage_wr_evt) begin
      staging <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (commit_evt) begin
      active <= staging;
    end
  end

  // key register is write-only: only the staging address returns data
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_A) bus_rdata = staging;
  end

  // R2
  stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_wr_evt |=> (staging == $past(bus_wdata)));

  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (active == $past(staging)));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(active));

  // R4
  key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == KEY_A) |-> (bus_rdata == '0));

endmodule

// File: rtl/mmk_decoder.sv
module mmk_decoder
  import mmk_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter int unsigned BASE   = 32'h1000,
  parameter int unsigned WIN    = 32'h0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              overlay,
  output logic              flash_sel,
  output logic              rom_sel,
  output logic [ADDR_W-1:0] offset
);

  localparam logic [31:0] BASE_L = 32'(BASE);
  localparam logic [31:0] WIN_L  = 32'(WIN);

  logic [31:0] addr_ext;
  tgt_e        tgt;

  assign addr_ext  = 32'(addr);
  assign tgt       = pick_target(addr_ext, BASE_L, WIN_L, overlay);
  assign flash_sel = (tgt == TGT_FLASH);
  assign rom_sel   = (tgt == TGT_ROM);
  assign offset    = ADDR_W'(local_off(addr_ext, BASE_L));

  // R7
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_sel && rom_sel));

  // R7
  rom_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (overlay && (addr_ext < BASE_L + WIN_L)));

  // R6
  flash_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!overlay && addr_ext >= BASE_L) |-> flash_sel);

  // R8
  low_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ext < BASE_L) |-> (!flash_sel && !rom_sel && offset == '0));

endmodule

// File: rtl/memmap_keyed_ctrl.sv
module memmap_keyed_ctrl #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 32'h0FD0,
  parameter int unsigned KEY_ADDR  = 32'h0FD1,
  parameter int unsigned KEY_VAL   = 32'hD5,
  parameter int unsigned BASE      = 32'h1000,
  parameter int unsigned WIN       = 32'h0800,
  parameter int          BOOT_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DATA_W-1:0] mon_active,
  input  logic [ADDR_W-1:0] code_addr,
  output logic              code_flash_sel,
  output logic              code_rom_sel,
  output logic [ADDR_W-1:0] code_offset,
  input  logic [ADDR_W-1:0] data_addr,
  output logic              data_flash_sel,
  output logic              data_rom_sel,
  output logic [ADDR_W-1:0] data_offset
);

  localparam int NSPACE = 2;

  logic [DATA_W-1:0] staging_q;
  logic [DATA_W-1:0] active_q;
  logic              commit_evt;
  logic              overlay_on;

  logic [NSPACE-1:0][ADDR_W-1:0] sp_addr;
  logic [NSPACE-1:0]             sp_flash;
  logic [NSPACE-1:0]             sp_rom;
  logic [NSPACE-1:0][ADDR_W-1:0] sp_off;

  mmk_ctrl_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR),
    .KEY_ADDR (KEY_ADDR),
    .KEY_VAL  (KEY_VAL)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (reg_addr),
    .bus_wr    (reg_wr),
    .bus_wdata (reg_wdata),
    .bus_rdata (reg_rdata),
    .staging   (staging_q),
    .active    (active_q),
    .commit_evt(commit_evt)
  );

  assign overlay_on = active_q[BOOT_BIT];
  assign mon_active = active_q;

  assign sp_addr[0] = code_addr;
  assign sp_addr[1] = data_addr;

  for (genvar s = 0; s < NSPACE; s++) begin : g_space
    mmk_decoder #(
      .ADDR_W(ADDR_W),
      .BASE  (BASE),
      .WIN   (WIN)
    ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (sp_addr[s]),
      .overlay  (overlay_on),
      .flash_sel(sp_flash[s]),
      .rom_sel  (sp_rom[s]),
      .offset   (sp_off[s])
    );
  end

  assign code_flash_sel = sp_flash[0];
  assign code_rom_sel   = sp_rom[0];
  assign code_offset    = sp_off[0];
  assign data_flash_sel = sp_flash[1];
  assign data_rom_sel   = sp_rom[1];
  assign data_offset    = sp_off[1];

  // R10
  mapping_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(overlay_on));

  // R5
  monitor_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (mon_active == $past(staging_q)));

endmodule

// File: tb/memmap_keyed_ctrl_tb.sv
module memmap_keyed_ctrl_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = 16'h0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h0;
  logic [7:0]  reg_rdata;
  logic [7:0]  mon_active;
  logic [15:0] code_addr = 16'h0;
  logic        code_flash_sel, code_rom_sel;
  logic [15:0] code_offset;
  logic [15:0] data_addr = 16'h0;
  logic        data_flash_sel, data_rom_sel;
  logic [15:0] data_offset;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_stg = 8'h00;
  logic [7:0] m_act = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  memmap_keyed_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mon_active(mon_active),
    .code_addr(code_addr), .code_flash_sel(code_flash_sel),
    .code_rom_sel(code_rom_sel), .code_offset(code_offset),
    .data_addr(data_addr), .data_flash_sel(data_flash_sel),
    .data_rom_sel(data_rom_sel), .data_offset(data_offset)
  );

  // expected {flash, rom, offset} built from the requirement text
  function automatic logic [17:0] exp_dec(input logic [15:0] a, input logic [7:0] act);
    logic in_map, in_win, boot;
    boot   = act[5];
    in_map = (a >= 16'h1000);
    in_win = in_map && (a <= 16'h17FF);
    if (!in_map)          return {1'b0, 1'b0, 16'h0};
    else if (boot && in_win) return {1'b0, 1'b1, a - 16'h1000};
    else                  return {1'b1, 1'b0, a - 16'h1000};
  endfunction

  function automatic string req_of(input logic [15:0] a, input logic [7:0] act);
    if (a < 16'h1000) return "R8";
    if (act[5] && a <= 16'h17FF) return "R7";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive both spaces, settle, compare against a given active value
  task automatic probe(input logic [15:0] ca, input logic [15:0] da,
                       input logic [7:0] act, input string tag);
    code_addr = ca;
    data_addr = da;
    #1;
    chk({tag, " code ", req_of(ca, act)},
        {14'h0, code_flash_sel, code_rom_sel, code_offset}, {14'h0, exp_dec(ca, act)});
    chk({tag, " data ", req_of(da, act)},
        {14'h0, data_flash_sel, data_rom_sel, data_offset}, {14'h0, exp_dec(da, act)});
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 16'h0FD0) m_stg = d;
    if (a == 16'h0FD1 && d == 8'hD5) m_act = m_stg;
  endtask

  task automatic read_chk(input logic [15:0] a, input string req);
    reg_addr = a;
    #1;
    chk(req, {24'h0, reg_rdata}, {24'h0, (a == 16'h0FD0) ? m_stg : 8'h00});
  endtask

  function automatic logic [15:0] rnd_addr();
    case ($urandom % 5)
      0: return 16'($urandom % 16'h1000);
      1: return 16'h1000 + 16'($urandom % 16'h0800);
      2: return ($urandom % 2) ? 16'h17FF : 16'h1800;
      3: return ($urandom % 2) ? 16'h0FFF : 16'h1000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_chk(16'h0FD0, "R1");
    chk("R1 mon", {24'h0, mon_active}, 32'h0);
    probe(16'h1000, 16'hFFFF, 8'h00, "R1");

    // R2 staging alone leaves mapping alone
    bus_write(16'h0FD0, 8'h20);
    read_chk(16'h0FD0, "R2");
    chk("R2 mon", {24'h0, mon_active}, 32'h0);
    probe(16'h1000, 16'h17FF, 8'h00, "R2");

    // R4 wrong key ignored, key address reads zero
    bus_write(16'h0FD1, 8'h5D);
    chk("R4 mon", {24'h0, mon_active}, 32'h0);
    read_chk(16'h0FD1, "R4");
    probe(16'h1000, 16'h1000, 8'h00, "R4");

    // R10 commit and decode in the same cycle
    @(negedge clk);
    reg_addr = 16'h0FD1; reg_wr = 1'b1; reg_wdata = 8'hD5;
    probe(16'h1000, 16'h17FF, 8'h00, "R10 same-cycle");
    @(negedge clk);
    reg_wr = 1'b0;
    m_act = m_stg;
    probe(16'h1000, 16'h17FF, 8'h20, "R10 next-cycle");
    chk("R3 mon", {24'h0, mon_active}, 32'h20);
    chk("R5 mon", {24'h0, mon_active}, {24'h0, m_act});

    // R7 window edges
    probe(16'h1800, 16'h17FF, m_act, "R7 edge");
    probe(16'h0FFF, 16'hFFFF, m_act, "R8 edge");

    // R9 other bits do not steer decoding
    bus_write(16'h0FD0, 8'hDF);
    bus_write(16'h0FD1, 8'hD5);
    chk("R9 mon", {24'h0, mon_active}, 32'hDF);
    probe(16'h1000, 16'h17FF, 8'hDF, "R9");

    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 4)
        0: bus_write(16'h0FD0, 8'($urandom));
        1: bus_write(16'h0FD1, ($urandom % 2) ? 8'hD5 : 8'($urandom));
        2: read_chk(($urandom % 2) ? 16'h0FD0 : 16'h0FD1, "R4 rd");
        default: begin
          probe(rnd_addr(), rnd_addr(), m_act, "rnd");
          chk("R5 rnd", {24'h0, mon_active}, {24'h0, m_act});
        end
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule